// File: doc/BRIEF.md
# Unhalted Reference Cycle Counters

This block is a compact performance-monitoring unit for a single core. A base reference clock is delivered to it as a one-cycle strobe that is synchronous to the core clock. Three kinds of counter advance on that strobe:

- A timestamp counter that always runs.
- A fixed-function unhalted counter that adds the nominal multiplier ratio on each strobe.
- A set of programmable counters that add one per strobe, when their event select names the unhalted reference-clock event.

Both unhalted kinds stop while the core reports itself halted. Because they stop and resume together, the fixed counter always reads as the ratio times a programmable counter that was started with it.

Software reaches every register through one 32-bit index that is shared by a write port and a registered read port. The nominal ratio is a strap input and can be read back through a read-only platform register. All counters are 48 bits wide, wrap silently, and can be preloaded or cleared by software.

Top module: `refcyc_pmu`

## Requirements
- R1: After reset all counters, the fixed enable and every event select read as zero, and `rd_valid` is low.
- R2: The timestamp counter (index 0x8000_0000) adds `nominal_ratio` on every cycle with `ref_tick` high, whatever `core_halted` is, and holds otherwise.
- R3: The fixed unhalted counter (index 0x4000_0002) adds `nominal_ratio` on a `ref_tick` cycle only when `core_halted` is low and bit 0 of the fixed control register (index 0x8000_0002) is set. While halted it keeps its value and resumes from it with no loss.
- R4: Programmable counter k (index k, bits 31 and 30 clear) adds exactly 1 on a `ref_tick` cycle with `core_halted` low when its event select (index 0x8000_0004+k) has the enable bit [16] set, code [7:0] = 0x3C and unit mask [15:8] = 0x01.
- R5: With the enable bit clear, or with any other code or unit mask, a programmable counter holds its value.
- R6: Counters are 48 bits wide and wrap to zero past 2^48-1.
- R7: A write to a counter's index loads `wr_data[47:0]`, and takes priority over an increment in the same cycle.
- R8: The read index decodes as follows. With bit 31 clear and bit 30 set, bits [7:0] select a fixed counter: slot 2 is the unhalted counter and other slots read zero. With bits 31 and 30 clear, bits [7:0] select a programmable counter, and slots at or above the counter count read zero.
- R9: With bit 31 set, bits [7:0] select a system register: 0 is the timestamp, 1 is platform info, 2 is fixed control, and 4+k is event select k. Platform info returns `nominal_ratio` in bits [15:8] with all other bits zero, and ignores writes.
- R10: `rd_en` yields `rd_valid` high for exactly one cycle on the next cycle. `rd_data` then holds the register value from before the update made at that edge, so a read that coincides with an increment returns the pre-increment value.
- R11: When the fixed and programmable counters are cleared and enabled together, the fixed counter equals `nominal_ratio` times the programmable counter after any mix of ticks and halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per reference-clock period |
| core_halted | input | 1 | High while the core is halted |
| nominal_ratio | input | 8 | Nominal multiplier ratio strap |
| wr_en | input | 1 | Register write strobe |
| wr_index | input | 32 | Index of the register to write |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_index | input | 32 | Index of the register to read |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 64 | Read data, zero-extended |

## Verification
The hardest situations to reach from the ports are the 48-bit wrap and a software write landing on the same edge as a reference tick. A random walk would take about 2^40 strobes to reach the wrap at any realistic ratio. The bench therefore preloads counters a few counts below 2^48 and fires a tick, and it issues writes and reads deliberately in tick cycles. The random phase then draws its preload values often from just below the wrap point, while ticks, halts, event selections and reads all vary together.

// File: rtl/refcyc_pkg.sv
// Package: shared index encoding, event codes and register types for
// the unhalted reference-cycle counter block.
package refcyc_pkg;

    localparam int IDX_W       = 32;
    localparam int SYS_BIT     = 31;
    localparam int FIXED_BIT   = 30;
    localparam int PLAT_LSB    = 8;

    localparam logic [7:0] SLOT_TSC       = 8'd0;
    localparam logic [7:0] SLOT_PLATFORM  = 8'd1;
    localparam logic [7:0] SLOT_FIXCTL    = 8'd2;
    localparam logic [7:0] SLOT_EVSEL0    = 8'd4;
    localparam logic [7:0] FIXED_REF_SLOT = 8'd2;

    localparam logic [7:0] EV_REFCLK_CODE  = 8'h3C;
    localparam logic [7:0] EV_REFCLK_UMASK = 8'h01;

    typedef enum logic [1:0] {
        SP_PROG  = 2'd0,
        SP_FIXED = 2'd1,
        SP_SYS   = 2'd2
    } space_e;

    typedef struct packed {
        space_e     space;
        logic [7:0] slot;
    } reg_sel_t;

    typedef struct packed {
        logic       enable;
        logic [7:0] umask;
        logic [7:0] code;
    } evsel_t;

    localparam int EVSEL_W = $bits(evsel_t);

    // Split an access index into its address space and slot number.
    function automatic reg_sel_t decode_index(input logic [IDX_W-1:0] idx);
        reg_sel_t s;
        s.slot = idx[7:0];
        if (idx[SYS_BIT])        s.space = SP_SYS;
        else if (idx[FIXED_BIT]) s.space = SP_FIXED;
        else                     s.space = SP_PROG;
        return s;
    endfunction

endpackage

// File: rtl/refcyc_counter.sv
// Module: refcyc_counter
// A wrapping counter that adds a step when told to and loads a preload
// value on a software write.
// Assumes: load and inc are single-cycle qualifiers, and load has
// priority over inc.
module refcyc_counter #(
    parameter int CNT_W  = 48,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    input  logic              inc,
    input  logic [STEP_W-1:0] step,
    output logic [CNT_W-1:0]  count
);

    // Count register: load wins, otherwise add step modulo 2^CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (inc) begin
            count <= count + CNT_W'(step);
        end
    end

endmodule

// File: rtl/refcyc_evsel.sv
// Module: refcyc_evsel
// Event-select register for one programmable counter, plus the match
// against the unhalted reference-clock event.
// Assumes: only the enable, unit-mask and code fields are stored, and
// unused write bits are dropped.
module refcyc_evsel
    import refcyc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [EVSEL_W-1:0] wr_data,
    output evsel_t             evsel_q,
    output logic               match
);

    // Select register: cleared at reset, replaced on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evsel_q <= '0;
        end else if (wr) begin
            evsel_q <= evsel_t'(wr_data);
        end
    end

    // Counting permitted only for the supported code and unit mask.
    always_comb begin
        match = evsel_q.enable
             && (evsel_q.code  == EV_REFCLK_CODE)
             && (evsel_q.umask == EV_REFCLK_UMASK);
    end

endmodule

// File: rtl/refcyc_readmux.sv
// Module: refcyc_readmux
// Decodes the read index, selects one register and captures it on the
// clock edge that sees rd_en.
// Assumes: its inputs are register outputs, so the captured value is
// the one from before that edge's updates.
module refcyc_readmux
    import refcyc_pkg::*;
#(
    parameter int CNT_W    = 48,
    parameter int DATA_W   = 64,
    parameter int RATIO_W  = 8,
    parameter int NUM_PROG = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en,
    input  logic [IDX_W-1:0]               rd_index,
    input  logic [CNT_W-1:0]               tsc,
    input  logic [CNT_W-1:0]               fix,
    input  logic [NUM_PROG-1:0][CNT_W-1:0] prog,
    input  evsel_t [NUM_PROG-1:0]          evsel,
    input  logic                           fix_en,
    input  logic [RATIO_W-1:0]             ratio,
    output logic                           rd_valid,
    output logic [DATA_W-1:0]              rd_data
);

    reg_sel_t          rsel;
    logic [DATA_W-1:0] rd_val;

    // Read selection: pick the addressed register, or zero if none.
    always_comb begin
        rsel   = decode_index(rd_index);
        rd_val = '0;
        case (rsel.space)
            SP_SYS: begin
                if (rsel.slot == SLOT_TSC) begin
                    rd_val = DATA_W'(tsc);
                end else if (rsel.slot == SLOT_PLATFORM) begin
                    rd_val = DATA_W'(ratio) << PLAT_LSB;
                end else if (rsel.slot == SLOT_FIXCTL) begin
                    rd_val = DATA_W'(fix_en);
                end else begin
                    for (int k = 0; k < NUM_PROG; k++) begin
                        if (rsel.slot == SLOT_EVSEL0 + 8'(k)) begin
                            rd_val = DATA_W'(evsel[k]);
                        end
                    end
                end
            end
            SP_FIXED: begin
                if (rsel.slot == FIXED_REF_SLOT) begin
                    rd_val = DATA_W'(fix);
                end
            end
            default: begin
                for (int k = 0; k < NUM_PROG; k++) begin
                    if (rsel.slot == 8'(k)) begin
                        rd_val = DATA_W'(prog[k]);
                    end
                end
            end
        endcase
    end

    // Read capture: one-cycle valid pulse with the selected value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= rd_val;
            end
        end
    end

endmodule

// File: rtl/refcyc_pmu.sv
// Module: refcyc_pmu (top)
// Holds a timestamp counter, a fixed unhalted reference counter that
// counts by the nominal ratio, and NUM_PROG programmable counters that
// count the unhalted reference event once per tick. All are reached
// through one index space for writes and registered reads.
// Assumes: ref_tick is a one-cycle strobe synchronous to clk, and
// nominal_ratio is a static strap.
module refcyc_pmu
    import refcyc_pkg::*;
#(
    parameter int CNT_W    = 48,
    parameter int DATA_W   = 64,
    parameter int RATIO_W  = 8,
    parameter int NUM_PROG = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_tick,
    input  logic               core_halted,
    input  logic [RATIO_W-1:0] nominal_ratio,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_index,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   rd_index,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data
);

    localparam int PROG_STEP_W = 1;

    reg_sel_t                     wsel;
    logic                         tsc_load;
    logic                         fix_load;
    logic                         fixctl_wr;
    logic                         fix_en;
    logic                         unhalted_tick;
    logic [CNT_W-1:0]             tsc_q;
    logic [CNT_W-1:0]             fix_q;
    logic [NUM_PROG-1:0][CNT_W-1:0] prog_q;
    logic [NUM_PROG-1:0]          prog_load;
    logic [NUM_PROG-1:0]          evsel_wr;
    logic [NUM_PROG-1:0]          prog_match;
    evsel_t [NUM_PROG-1:0]        evsel_q;

    // Write decode: turn the write index into per-register strobes.
    always_comb begin
        wsel      = decode_index(wr_index);
        tsc_load  = wr_en && (wsel.space == SP_SYS)   && (wsel.slot == SLOT_TSC);
        fixctl_wr = wr_en && (wsel.space == SP_SYS)   && (wsel.slot == SLOT_FIXCTL);
        fix_load  = wr_en && (wsel.space == SP_FIXED) && (wsel.slot == FIXED_REF_SLOT);
        for (int k = 0; k < NUM_PROG; k++) begin
            prog_load[k] = wr_en && (wsel.space == SP_PROG) && (wsel.slot == 8'(k));
            evsel_wr[k]  = wr_en && (wsel.space == SP_SYS)
                        && (wsel.slot == SLOT_EVSEL0 + 8'(k));
        end
    end

    // Halt gate: a tick that the unhalted counters may see.
    always_comb begin
        unhalted_tick = ref_tick && !core_halted;
    end

    // Fixed control register: bit 0 enables the fixed counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fix_en <= 1'b0;
        end else if (fixctl_wr) begin
            fix_en <= wr_data[0];
        end
    end

    refcyc_counter #(.CNT_W(CNT_W), .STEP_W(RATIO_W)) tsc_cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tsc_load),
        .load_val (wr_data[CNT_W-1:0]),
        .inc      (ref_tick),
        .step     (nominal_ratio),
        .count    (tsc_q)
    );

    refcyc_counter #(.CNT_W(CNT_W), .STEP_W(RATIO_W)) fix_cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fix_load),
        .load_val (wr_data[CNT_W-1:0]),
        .inc      (unhalted_tick && fix_en),
        .step     (nominal_ratio),
        .count    (fix_q)
    );

    for (genvar g = 0; g < NUM_PROG; g++) begin : g_prog
        refcyc_evsel evsel_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (evsel_wr[g]),
            .wr_data (wr_data[EVSEL_W-1:0]),
            .evsel_q (evsel_q[g]),
            .match   (prog_match[g])
        );

        refcyc_counter #(.CNT_W(CNT_W), .STEP_W(PROG_STEP_W)) cnt_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (prog_load[g]),
            .load_val (wr_data[CNT_W-1:0]),
            .inc      (unhalted_tick && prog_match[g]),
            .step     (1'b1),
            .count    (prog_q[g])
        );
    end

    refcyc_readmux #(
        .CNT_W    (CNT_W),
        .DATA_W   (DATA_W),
        .RATIO_W  (RATIO_W),
        .NUM_PROG (NUM_PROG)
    ) readmux_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_index (rd_index),
        .tsc      (tsc_q),
        .fix      (fix_q),
        .prog     (prog_q),
        .evsel    (evsel_q),
        .fix_en   (fix_en),
        .ratio    (nominal_ratio),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/refcyc_pmu_chk.sv
// Module: refcyc_pmu_chk
// Checker bound into refcyc_pmu. It relates counter state to the
// tick, halt, enable and write inputs across clock edges.
// Assumes: it is connected to the top's internal counter and strobe
// signals through the bind below.
module refcyc_pmu_chk #(
    parameter int CNT_W    = 48,
    parameter int DATA_W   = 64,
    parameter int RATIO_W  = 8,
    parameter int NUM_PROG = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           ref_tick,
    input logic                           core_halted,
    input logic [RATIO_W-1:0]             nominal_ratio,
    input logic [DATA_W-1:0]              wr_data,
    input logic                           rd_en,
    input logic                           rd_valid,
    input logic [CNT_W-1:0]               tsc_q,
    input logic [CNT_W-1:0]               fix_q,
    input logic [NUM_PROG-1:0][CNT_W-1:0] prog_q,
    input logic                           tsc_load,
    input logic                           fix_load,
    input logic                           fix_en,
    input logic [NUM_PROG-1:0]            prog_load,
    input logic [NUM_PROG-1:0]            prog_match
);

    p_tsc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tick && !tsc_load) |=> tsc_q == $past(tsc_q) + CNT_W'($past(nominal_ratio)));

    p_tsc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_tick && !tsc_load) |=> $stable(tsc_q));

    p_fix_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_halted || !ref_tick || !fix_en) && !fix_load) |=> $stable(fix_q));

    p_fix_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tick && !core_halted && fix_en && !fix_load)
        |=> fix_q == $past(fix_q) + CNT_W'($past(nominal_ratio)));

    p_tsc_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tsc_load |=> tsc_q == $past(wr_data[CNT_W-1:0]));

    p_fix_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fix_load |=> fix_q == $past(wr_data[CNT_W-1:0]));

    p_rd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_rd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    for (genvar g = 0; g < NUM_PROG; g++) begin : g_prog_chk
        p_prog_unit_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !prog_load[g] |=> (prog_q[g] - $past(prog_q[g])) <= CNT_W'(1));

        p_prog_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ((!prog_match[g] || core_halted || !ref_tick) && !prog_load[g])
            |=> $stable(prog_q[g]));
    end

endmodule

bind refcyc_pmu refcyc_pmu_chk #(
    .CNT_W    (CNT_W),
    .DATA_W   (DATA_W),
    .RATIO_W  (RATIO_W),
    .NUM_PROG (NUM_PROG)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ref_tick      (ref_tick),
    .core_halted   (core_halted),
    .nominal_ratio (nominal_ratio),
    .wr_data       (wr_data),
    .rd_en         (rd_en),
    .rd_valid      (rd_valid),
    .tsc_q         (tsc_q),
    .fix_q         (fix_q),
    .prog_q        (prog_q),
    .tsc_load      (tsc_load),
    .fix_load      (fix_load),
    .fix_en        (fix_en),
    .prog_load     (prog_load),
    .prog_match    (prog_match)
);

// File: tb/refcyc_pmu_tb_top.sv
// Bench for refcyc_pmu: directed corner cases, then seeded random
// traffic, all checked against a bench model built from the requirements.
module refcyc_pmu_tb_top;

    localparam logic [31:0] I_TSC   = 32'h8000_0000;
    localparam logic [31:0] I_PLAT  = 32'h8000_0001;
    localparam logic [31:0] I_FCTL  = 32'h8000_0002;
    localparam logic [31:0] I_EV0   = 32'h8000_0004;
    localparam logic [31:0] I_EV1   = 32'h8000_0005;
    localparam logic [31:0] I_FIX2  = 32'h4000_0002;
    localparam logic [31:0] I_FIX0  = 32'h4000_0000;
    localparam logic [31:0] I_PROG0 = 32'h0000_0000;
    localparam logic [31:0] I_PROG1 = 32'h0000_0001;
    localparam logic [47:0] TOP48   = 48'hFFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        core_halted = 1'b0;
    logic [7:0]  nominal_ratio = 8'd27;
    logic        wr_en = 1'b0;
    logic [31:0] wr_index = '0;
    logic [63:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_index = '0;
    logic        rd_valid;
    logic [63:0] rd_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    refcyc_pmu dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ref_tick      (ref_tick),
        .core_halted   (core_halted),
        .nominal_ratio (nominal_ratio),
        .wr_en         (wr_en),
        .wr_index      (wr_index),
        .wr_data       (wr_data),
        .rd_en         (rd_en),
        .rd_index      (rd_index),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data)
    );

    always #10 clk = ~clk;

    // ---------------- bench model ----------------
    logic [47:0] m_tsc, m_fix;
    logic [47:0] m_prog [2];
    logic        m_fixen;
    logic [16:0] m_ev [2];
    logic        exp_valid = 1'b0;
    logic [63:0] exp_data = '0;
    string       exp_tag = "R10";

    function automatic logic [63:0] mread(input logic [31:0] idx);
        if (idx[31]) begin
            case (idx[7:0])
                8'd0: return 64'(m_tsc);
                8'd1: return 64'(nominal_ratio) << 8;
                8'd2: return 64'(m_fixen);
                8'd4: return 64'(m_ev[0]);
                8'd5: return 64'(m_ev[1]);
                default: return 64'd0;
            endcase
        end else if (idx[30]) begin
            return (idx[7:0] == 8'd2) ? 64'(m_fix) : 64'd0;
        end else begin
            return (idx[7:0] < 8'd2) ? 64'(m_prog[idx[0]]) : 64'd0;
        end
    endfunction

    function automatic string tag_of(input logic [31:0] idx);
        if (idx[31]) return (idx[7:0] == 8'd0) ? "R2" : "R9";
        if (idx[30]) return (idx[7:0] == 8'd2) ? "R3" : "R8";
        return (idx[7:0] < 8'd2) ? "R4" : "R8";
    endfunction

    function automatic bit ev_hit(input logic [16:0] ev);
        return ev[16] && ev[7:0] == 8'h3C && ev[15:8] == 8'h01;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tsc = '0; m_fix = '0; m_prog[0] = '0; m_prog[1] = '0;
            m_fixen = 1'b0; m_ev[0] = '0; m_ev[1] = '0;
            exp_valid = 1'b0;
        end else begin
            exp_valid = rd_en;
            if (rd_en) begin
                exp_data = mread(rd_index);
                exp_tag  = tag_of(rd_index);
            end
            if (ref_tick) begin
                m_tsc = m_tsc + 48'(nominal_ratio);
                if (!core_halted && m_fixen) m_fix = m_fix + 48'(nominal_ratio);
                for (int k = 0; k < 2; k++)
                    if (!core_halted && ev_hit(m_ev[k])) m_prog[k] = m_prog[k] + 48'd1;
            end
            if (wr_en) begin
                if (wr_index[31]) begin
                    case (wr_index[7:0])
                        8'd0: m_tsc = wr_data[47:0];
                        8'd2: m_fixen = wr_data[0];
                        8'd4: m_ev[0] = wr_data[16:0];
                        8'd5: m_ev[1] = wr_data[16:0];
                        default: ;
                    endcase
                end else if (wr_index[30]) begin
                    if (wr_index[7:0] == 8'd2) m_fix = wr_data[47:0];
                end else if (wr_index[7:0] < 8'd2) begin
                    m_prog[wr_index[0]] = wr_data[47:0];
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: check the last cycle's results at the falling edge, then drive.
    task automatic cyc(input bit tk, input bit hl, input bit we, input logic [31:0] wi,
                       input logic [63:0] wd, input bit re, input logic [31:0] ri);
        @(negedge clk);
        chk("R10", 64'(rd_valid), 64'(exp_valid));
        if (exp_valid) chk(exp_tag, rd_data, exp_data);
        ref_tick = tk; core_halted = hl; wr_en = we; wr_index = wi;
        wr_data = wd; rd_en = re; rd_index = ri;
    endtask

    task automatic idle();
        cyc(0, 0, 0, '0, '0, 0, '0);
    endtask

    task automatic wr(input logic [31:0] wi, input logic [63:0] wd);
        cyc(0, 0, 1, wi, wd, 0, '0);
    endtask

    task automatic rd(input logic [31:0] ri);
        cyc(0, 0, 0, '0, '0, 1, ri);
        idle();
    endtask

    function automatic logic [31:0] pick_idx();
        case ($urandom % 10)
            0: return I_TSC;
            1: return I_PLAT;
            2: return I_FCTL;
            3: return I_EV0;
            4: return I_EV1;
            5: return I_FIX2;
            6: return 32'h4000_0000 | ($urandom % 4);
            7: return I_PROG0;
            8: return I_PROG1;
            default: return ($urandom % 8);
        endcase
    endfunction

    function automatic logic [63:0] pick_data(input logic [31:0] idx);
        if (idx == I_EV0 || idx == I_EV1) begin
            case ($urandom % 4)
                0: return 64'h1_013C;
                1: return 64'h0_013C;
                2: return 64'h1_023C;
                default: return 64'h1_013D;
            endcase
        end
        if ($urandom % 2) return 64'(TOP48 - 48'($urandom % 64));
        return {$urandom, $urandom};
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    logic [63:0] v_fix, v_p0;

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1", 64'(rd_valid), 64'd0);
        rst_n = 1'b1;

        // R1: reset values
        rd(I_TSC);   chk("R1", rd_data, 64'd0);
        rd(I_FIX2);  chk("R1", rd_data, 64'd0);
        rd(I_PROG0); chk("R1", rd_data, 64'd0);
        rd(I_EV0);   chk("R1", rd_data, 64'd0);
        rd(I_FCTL);  chk("R1", rd_data, 64'd0);

        // R9: platform info shows the ratio in [15:8] and ignores writes
        rd(I_PLAT); chk("R9", rd_data, 64'h1B00);
        wr(I_PLAT, 64'hFFFF_FFFF);
        rd(I_PLAT); chk("R9", rd_data, 64'h1B00);

        // R3 R4 R5 R11: enable, then 40 ticks with 10 halted
        wr(I_FCTL, 64'd1);
        wr(I_EV0, 64'h1_013C);
        wr(I_EV1, 64'h1_023C);
        for (int i = 0; i < 40; i++) cyc(1, (i >= 10 && i < 20), 0, '0, '0, 0, '0);
        rd(I_FIX2);  v_fix = rd_data; chk("R3", v_fix, 64'd810);
        rd(I_PROG0); v_p0 = rd_data;  chk("R4", v_p0, 64'd30);
        rd(I_PROG1); chk("R5", rd_data, 64'd0);
        chk("R11", v_fix, v_p0 * 64'd27);
        rd(I_TSC);   chk("R2", rd_data, 64'd1080);

        // R8: index decode of fixed and programmable spaces
        rd(I_FIX0);        chk("R8", rd_data, 64'd0);
        rd(32'h0000_0007); chk("R8", rd_data, 64'd0);
        rd(32'h4000_0002); chk("R8", rd_data, 64'd810);

        // R10: a read in a tick cycle returns the pre-increment value
        wr(I_TSC, 64'd100);
        cyc(1, 0, 0, '0, '0, 1, I_TSC);
        idle(); chk("R10", rd_data, 64'd100);
        rd(I_TSC); chk("R2", rd_data, 64'd127);

        // R7: write wins over a same-cycle increment
        cyc(1, 0, 1, I_TSC, 64'd500, 0, '0);
        rd(I_TSC); chk("R7", rd_data, 64'd500);
        cyc(1, 0, 1, I_FIX2, 64'd1000, 0, '0);
        rd(I_FIX2); chk("R7", rd_data, 64'd1000);

        // R6: wrap past 2^48-1
        wr(I_FIX2, 64'(TOP48 - 48'd9));
        cyc(1, 0, 0, '0, '0, 0, '0);
        rd(I_FIX2); chk("R6", rd_data, 64'd17);
        wr(I_PROG0, 64'(TOP48));
        cyc(1, 0, 0, '0, '0, 0, '0);
        rd(I_PROG0); chk("R6", rd_data, 64'd0);

        // R5: enable clear holds the counter
        wr(I_EV0, 64'h0_013C);
        cyc(1, 0, 0, '0, '0, 0, '0);
        rd(I_PROG0); chk("R5", rd_data, 64'd0);

        // Random traffic against the model, with a different ratio
        @(negedge clk); nominal_ratio = 8'd26;
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] wi, ri;
            wi = pick_idx();
            ri = pick_idx();
            cyc(($urandom % 3) != 0, ($urandom % 4) == 0, ($urandom % 6) == 0,
                wi, pick_data(wi), ($urandom % 2) == 1, ri);
        end
        idle();
        idle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule